// File: doc/BRIEF.md
# Page Write Load Window Controller

This block gathers a run of byte writes into one page of a byte-wide non-volatile memory and decides when the internal programming cycle begins. Each write arrives as a single-cycle event with a 17-bit address and a data byte. The low eight address bits pick the byte slot inside a 256-byte page, and the upper nine bits name the page. The first accepted write opens a load window and latches its page. Every later write must carry that same page to be taken.

The window has no fixed length. It stays open as long as each new accepted byte arrives within a timeout, counted in microsecond ticks, after the previous accepted byte. When a full timeout passes with no accepted byte, the block issues a one-cycle start pulse. It then holds a busy flag for a modelled programming time, also counted in ticks. While busy, it ignores all writes. A write-permit input lets a surrounding protection scheme veto any write.

Top module: `pgwin_ctrl`

## Requirements
- R1: After a synchronous active-low reset, buf_we, prog_start and prog_busy are 0, byte_cnt is 0 and page_addr is 0.
- R2: Conditions for the first write: the block is neither busy nor holding an open window, and wr_permit is 1. On the clock edge that samples such a wr_evt, the block latches page_addr = wr_addr[16:8] and sets byte_cnt to 1. In the cycle that follows, buf_we is 1 for exactly one cycle, with buf_idx = wr_addr[7:0] and buf_data = wr_data.
- R3: While a window is open, a permitted write whose wr_addr[16:8] equals page_addr is accepted. It drives the buffer port as in R2 and increments byte_cnt, which saturates at 256.
- R4: While a window is open, a write whose wr_addr[16:8] differs from page_addr is ignored. buf_we stays 0, byte_cnt and page_addr keep their values, and the timeout is not restarted.
- R5: prog_start is a one-cycle pulse, and prog_busy rises with it. It occurs on the edge of the TIMEOUT_US-th us_tick counted after the last accepted write, provided no write was accepted in between.
- R6: The window has no overall length limit. Writes that each arrive fewer than TIMEOUT_US ticks apart keep it open indefinitely.
- R7: prog_busy stays 1 until the edge of the PROG_US-th us_tick after prog_start, then returns to 0. Writes sampled while prog_busy is 1 are ignored.
- R8: A write sampled with wr_permit at 0 is ignored. It neither opens a window nor loads a byte.
- R9: When an accepted write and a us_tick share a cycle, the write wins. The timeout restarts from zero, so a further TIMEOUT_US ticks are needed before prog_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_evt | input | 1 | One-cycle write event (sampled write-strobe falling edge) |
| wr_addr | input | 17 | Write address; [16:8] page, [7:0] byte slot |
| wr_data | input | 8 | Write data |
| us_tick | input | 1 | One-cycle microsecond tick enable |
| wr_permit | input | 1 | 1 allows writes, 0 vetoes them |
| buf_we | output | 1 | Page buffer write strobe |
| buf_idx | output | 8 | Page buffer byte slot |
| buf_data | output | 8 | Page buffer write data |
| page_addr | output | 9 | Latched page address of the open or last window |
| byte_cnt | output | 9 | Bytes loaded into the current window (saturates at 256) |
| prog_start | output | 1 | One-cycle programming start pulse |
| prog_busy | output | 1 | High during modelled programming time |

## Verification
A write event sampled on one edge shows up on buf_we, buf_idx, buf_data, page_addr and byte_cnt right after that same edge. A rejected write shows its absence there too. prog_start and prog_busy change right after the edge that carries the deciding tick. prog_busy falls right after the edge carrying the PROG_US-th tick. The bench drives every input on the falling clock edge and samples one full period later, at the next falling edge, so every expected value falls in the half-cycle after its edge. Tick counts are stepped one short of each limit and then onto it, to show both the hold and the transition.

// File: rtl/pgwin_pkg.sv
// Package: shared types for the page write load window controller.
// Assumes nothing beyond a single clock domain.
package pgwin_pkg;

    // Controller phase: idle, window open for loading, programming.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } pgwin_phase_t;

endpackage

// File: rtl/pgwin_tick_timer.sv
// Module: pgwin_tick_timer
// Counts us ticks while enabled and flags the tick that reaches LIMIT.
// Assumes tick is a one-cycle pulse; clear has priority over counting.
// The count returns to zero when disabled, so each enable starts fresh.
module pgwin_tick_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic tick,
    output logic last
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    // Flag the tick that completes LIMIT counted ticks.
    always_comb begin
        last = en && tick && (cnt_q == W'(LIMIT - 1));
    end

    // Advance on each tick, restart on clear, rest at zero when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pgwin_page_track.sv
// Module: pgwin_page_track
// Holds the page address of the open window and the number of bytes
// loaded into it. Assumes take_first and take_more are never both high.
module pgwin_page_track #(
    parameter int PAGE_W = 9,
    parameter int CNT_W  = 9,
    parameter int MAXCNT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_first,
    input  logic              take_more,
    input  logic [PAGE_W-1:0] page_in,
    output logic [PAGE_W-1:0] page_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              match
);
    // Compare incoming page with the latched one.
    always_comb begin
        match = (page_in == page_q);
    end

    // Latch page on the first byte; count bytes with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            cnt_q  <= '0;
        end else if (take_first) begin
            page_q <= page_in;
            cnt_q  <= CNT_W'(1);
        end else if (take_more && (cnt_q != CNT_W'(MAXCNT))) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pgwin_load_fsm.sv
// Module: pgwin_load_fsm
// Phase control: decides which write events are accepted, when the
// window closes and when programming ends. Assumes to_last and pr_last
// come from timers enabled only in the load and program phases.
module pgwin_load_fsm
    import pgwin_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  logic         permit,
    input  logic         match,
    input  logic         to_last,
    input  logic         pr_last,
    output logic         take_first,
    output logic         take_more,
    output logic         start_q,
    output pgwin_phase_t ph_q
);
    pgwin_phase_t ph_d;
    logic         close_win;

    // Accept decisions and window close condition.
    always_comb begin
        take_first = evt && permit && (ph_q == PH_IDLE);
        take_more  = evt && permit && (ph_q == PH_LOAD) && match;
        close_win  = (ph_q == PH_LOAD) && to_last && !take_more;
    end

    // Next phase selection.
    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_IDLE: if (take_first) ph_d = PH_LOAD;
            PH_LOAD: if (close_win)  ph_d = PH_PROG;
            PH_PROG: if (pr_last)    ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase register and one-cycle start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            start_q <= 1'b0;
        end else begin
            ph_q    <= ph_d;
            start_q <= close_win;
        end
    end

endmodule

// File: rtl/pgwin_ctrl.sv
// Module: pgwin_ctrl (top)
// Page write load window controller. It collects same-page byte writes,
// closes the window after TIMEOUT_US idle ticks, then models programming
// for PROG_US ticks. Assumes wr_evt and us_tick are one-cycle pulses
// synchronous to clk.
module pgwin_ctrl
    import pgwin_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 256,
    parameter int TIMEOUT_US = 100,
    parameter int PROG_US    = 5000
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_evt,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [DATA_W-1:0]                     wr_data,
    input  logic                                  us_tick,
    input  logic                                  wr_permit,
    output logic                                  buf_we,
    output logic [$clog2(PAGE_BYTES)-1:0]         buf_idx,
    output logic [DATA_W-1:0]                     buf_data,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  page_addr,
    output logic [$clog2(PAGE_BYTES+1)-1:0]       byte_cnt,
    output logic                                  prog_start,
    output logic                                  prog_busy
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int CNT_W  = $clog2(PAGE_BYTES + 1);

    pgwin_phase_t ph;
    logic         take_first, take_more, page_match;
    logic         to_last, pr_last;

    pgwin_load_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (wr_evt),
        .permit     (wr_permit),
        .match      (page_match),
        .to_last    (to_last),
        .pr_last    (pr_last),
        .take_first (take_first),
        .take_more  (take_more),
        .start_q    (prog_start),
        .ph_q       (ph)
    );

    pgwin_page_track #(
        .PAGE_W (PAGE_W),
        .CNT_W  (CNT_W),
        .MAXCNT (PAGE_BYTES)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_first (take_first),
        .take_more  (take_more),
        .page_in    (wr_addr[ADDR_W-1:OFS_W]),
        .page_q     (page_addr),
        .cnt_q      (byte_cnt),
        .match      (page_match)
    );

    // Inactivity timer: restarted by every accepted byte.
    pgwin_tick_timer #(.LIMIT(TIMEOUT_US)) u_idle_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ph == PH_LOAD),
        .clr   (take_first || take_more),
        .tick  (us_tick),
        .last  (to_last)
    );

    // Programming time model.
    pgwin_tick_timer #(.LIMIT(PROG_US)) u_prog_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ph == PH_PROG),
        .clr   (1'b0),
        .tick  (us_tick),
        .last  (pr_last)
    );

    // Busy flag follows the programming phase register.
    always_comb begin
        prog_busy = (ph == PH_PROG);
    end

    // Registered page buffer write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_we   <= 1'b0;
            buf_idx  <= '0;
            buf_data <= '0;
        end else begin
            buf_we <= take_first || take_more;
            if (take_first || take_more) begin
                buf_idx  <= wr_addr[OFS_W-1:0];
                buf_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/pgwin_ctrl_chk.sv
// Module: pgwin_ctrl_chk
// Property checker for pgwin_ctrl, attached by bind below.
module pgwin_ctrl_chk #(
    parameter int PAGE_W = 9,
    parameter int CNT_W  = 9,
    parameter int MAXCNT = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_permit,
    input logic              buf_we,
    input logic [PAGE_W-1:0] page_addr,
    input logic [CNT_W-1:0]  byte_cnt,
    input logic              prog_start,
    input logic              prog_busy
);
    assert_reset_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!buf_we && !prog_start && !prog_busy && byte_cnt == '0));

    assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start);

    assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> prog_busy);

    assert_no_load_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> !buf_we);

    assert_cnt_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= CNT_W'(MAXCNT));

    assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(page_addr) |-> (byte_cnt == CNT_W'(1)));

    assert_permit_veto_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wr_permit) |-> !buf_we);

endmodule

bind pgwin_ctrl pgwin_ctrl_chk #(
    .PAGE_W (ADDR_W - $clog2(PAGE_BYTES)),
    .CNT_W  ($clog2(PAGE_BYTES + 1)),
    .MAXCNT (PAGE_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_permit  (wr_permit),
    .buf_we     (buf_we),
    .page_addr  (page_addr),
    .byte_cnt   (byte_cnt),
    .prog_start (prog_start),
    .prog_busy  (prog_busy)
);

// File: tb/pgwin_ctrl_bench.sv
// Directed bench for pgwin_ctrl with shortened tick limits.
module pgwin_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TO_US      = 4;
    localparam int PR_US      = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_evt = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        us_tick = 1'b0;
    logic        wr_permit = 1'b1;
    logic        buf_we;
    logic [7:0]  buf_idx;
    logic [7:0]  buf_data;
    logic [8:0]  page_addr;
    logic [8:0]  byte_cnt;
    logic        prog_start;
    logic        prog_busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgwin_ctrl #(.TIMEOUT_US(TO_US), .PROG_US(PR_US)) u_pgwin_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
        .wr_data(wr_data), .us_tick(us_tick), .wr_permit(wr_permit),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
        .page_addr(page_addr), .byte_cnt(byte_cnt),
        .prog_start(prog_start), .prog_busy(prog_busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One write event (optionally with a tick in the same cycle).
    task automatic wr(input logic [16:0] a, input logic [7:0] d, input bit tk = 0);
        @(negedge clk);
        wr_evt = 1'b1; wr_addr = a; wr_data = d; us_tick = tk;
        @(negedge clk);
        wr_evt = 1'b0; us_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); us_tick = 1'b1;
            @(negedge clk); us_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R1 buf_we", buf_we, 0);
        chk("R1 prog_start", prog_start, 0);
        chk("R1 prog_busy", prog_busy, 0);
        chk("R1 byte_cnt", byte_cnt, 0);
        chk("R1 page_addr", page_addr, 0);
    endtask

    task automatic t_first_and_same();
        wr(17'h12345, 8'hA5);
        chk("R2 buf_we", buf_we, 1);
        chk("R2 buf_idx", buf_idx, 8'h45);
        chk("R2 buf_data", buf_data, 8'hA5);
        chk("R2 page_addr", page_addr, 9'h123);
        chk("R2 byte_cnt", byte_cnt, 1);
        @(negedge clk);
        chk("R2 buf_we single", buf_we, 0);
        wr(17'h123FF, 8'h3C);
        chk("R3 buf_we", buf_we, 1);
        chk("R3 buf_idx", buf_idx, 8'hFF);
        chk("R3 byte_cnt", byte_cnt, 2);
    endtask

    task automatic t_foreign_timeout();
        ticks(TO_US - 1);
        chk("R5 no early start", prog_busy, 0);
        wr(17'h12400, 8'h77);
        chk("R4 foreign buf_we", buf_we, 0);
        chk("R4 foreign cnt", byte_cnt, 2);
        chk("R4 foreign page", page_addr, 9'h123);
        ticks(1);
        chk("R4 timeout not restarted start", prog_start, 1);
        chk("R5 busy", prog_busy, 1);
        @(negedge clk);
        chk("R5 start one cycle", prog_start, 0);
    endtask

    task automatic t_busy();
        wr(17'h12301, 8'h11);
        chk("R7 write during busy", buf_we, 0);
        chk("R7 cnt during busy", byte_cnt, 2);
        ticks(PR_US - 1);
        chk("R7 still busy", prog_busy, 1);
        ticks(1);
        chk("R7 busy drops", prog_busy, 0);
    endtask

    task automatic t_permit();
        wr_permit = 1'b0;
        wr(17'h00010, 8'h99);
        chk("R8 veto buf_we", buf_we, 0);
        chk("R8 veto cnt", byte_cnt, 2);
        chk("R8 veto page", page_addr, 9'h123);
        ticks(TO_US + 1);
        chk("R8 no window", prog_busy, 0);
        wr_permit = 1'b1;
    endtask

    task automatic t_long_window();
        int bad = 0;
        wr(17'h0AB00, 8'h00);
        for (int i = 1; i <= 20; i++) begin
            ticks(TO_US - 1);
            wr(17'h0AB00 + 17'(i), 8'(i));
            if (prog_busy || !buf_we) bad++;
        end
        chk("R6 window stays open", bad, 0);
        chk("R6 cnt", byte_cnt, 21);
        chk("R6 page", page_addr, 9'h0AB);
    endtask

    task automatic t_tick_with_write();
        ticks(TO_US - 1);
        wr(17'h0AB40, 8'h40, 1'b1);
        chk("R9 accepted", buf_we, 1);
        chk("R9 not started", prog_busy, 0);
        ticks(TO_US - 1);
        chk("R9 restart hold", prog_busy, 0);
        ticks(1);
        chk("R9 start", prog_start, 1);
        ticks(PR_US);
        chk("R9 done", prog_busy, 0);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 256; i++) wr(17'h1FF00 + 17'(i), 8'(i));
        chk("R3 cnt 256", byte_cnt, 256);
        chk("R2 new page", page_addr, 9'h1FF);
        wr(17'h1FF05, 8'h55);
        chk("R3 saturate", byte_cnt, 256);
        chk("R3 load after full", buf_we, 1);
        ticks(TO_US);
        chk("R5 start after page", prog_busy, 1);
        ticks(PR_US);
        chk("R7 idle again", prog_busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_and_same();
        t_foreign_timeout();
        t_busy();
        t_permit();
        t_long_window();
        t_tick_with_write();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule